// File: doc/BRIEF.md
# Multicycle Processor Control Sequencer

This block is the finite-state controller of a small multicycle processor whose datapath is one byte wide. The instruction register is still four bytes wide, so it is filled over several fetch beats. On each beat one byte lane of the instruction register is enabled, memory is read at the program counter, and the program counter moves on by one. After the last beat, a decode state computes the branch target. The controller then dispatches on the 6-bit opcode to a short run of execution states, and every path returns to the first fetch beat.

The controller handles register-register ALU operations, add-immediate, byte load, byte store, branch-on-equal and jump. If decode sees any other opcode, the controller goes straight back to fetch and writes nothing. Every control output depends only on the current state. The opcode input is sampled only at state transitions.

Top module: `mcsq_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, the outputs are those of fetch beat 0.
- R2: A fetch takes FETCH_BEATS cycles (default 4). Beat k drives ir_we_o with only bit k set, in ascending order. Each beat also drives mem_rd_o=1, addr_sel_o=0, alu_a_sel_o=0 (PC), alu_b_sel_o=1 (constant one), alu_op_o=0 (add), pc_we_o=1 and pc_sel_o=0 (ALU result).
- R3: The cycle after the last fetch beat is decode. Decode drives alu_a_sel_o=0, alu_b_sel_o=3 (branch offset) and alu_op_o=0, and asserts no write enable and no memory access.
- R4: The opcodes are matched after decode as follows: 000000 is register-register, 001000 is add-immediate, 100000 is byte load, 101000 is byte store, 000100 is branch-on-equal and 000010 is jump.
- R5: Register-register runs an execute cycle with alu_a_sel_o=1, alu_b_sel_o=0 and alu_op_o=2 (function field). It then runs a write-back cycle with reg_we_o=1, reg_dst_o=1 (rd) and wb_sel_o=0 (ALU), and then returns to fetch.
- R6: Add-immediate runs an execute cycle with alu_a_sel_o=1, alu_b_sel_o=2 (immediate) and alu_op_o=0. It then runs a write-back cycle with reg_we_o=1, reg_dst_o=0 (rt) and wb_sel_o=0.
- R7: Byte load runs three cycles. The address cycle has alu_a_sel_o=1, alu_b_sel_o=2 and alu_op_o=0. The read cycle has mem_rd_o=1 and addr_sel_o=1 (ALUOut). The write-back cycle has reg_we_o=1, reg_dst_o=0 and wb_sel_o=1 (memory data).
- R8: Byte store runs the same address cycle, then a write cycle with mem_wr_o=1 and addr_sel_o=1, and then returns to fetch.
- R9: Branch-on-equal runs one cycle with pc_we_cond_o=1, pc_sel_o=1 (ALUOut), alu_a_sel_o=1, alu_b_sel_o=0 and alu_op_o=1 (subtract), and then returns to fetch.
- R10: Jump runs one cycle with pc_we_o=1 and pc_sel_o=2 (jump target), and then returns to fetch.
- R11: Any other opcode moves from decode directly to fetch beat 0 and asserts no register write and no memory write.
- R12: mem_rd_o and mem_wr_o are never both high, pc_we_o and pc_we_cond_o are never both high, and at most one ir_we_o bit is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| opcode_i | input | 6 | Opcode field of the instruction register |
| pc_we_o | output | 1 | Unconditional PC write |
| pc_we_cond_o | output | 1 | PC write when the ALU result is zero |
| pc_sel_o | output | 2 | PC source: 0 ALU result, 1 ALUOut, 2 jump target |
| addr_sel_o | output | 1 | Memory address: 0 PC, 1 ALUOut |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| ir_we_o | output | FETCH_BEATS | Per-byte instruction register write enables |
| alu_a_sel_o | output | 1 | ALU operand A: 0 PC, 1 register A |
| alu_b_sel_o | output | 2 | ALU operand B: 0 register B, 1 constant one, 2 immediate, 3 branch offset |
| alu_op_o | output | 2 | ALU class: 0 add, 1 subtract, 2 function field |
| reg_dst_o | output | 1 | Destination register: 0 rt, 1 rd |
| wb_sel_o | output | 1 | Write-back data: 0 ALUOut, 1 memory data |
| reg_we_o | output | 1 | Register file write |

## Verification
The assertions assume that the opcode stays stable from the cycle after the last fetch beat until the instruction returns to fetch. The surrounding datapath guarantees this, because the instruction register is not written again before then. The stimulus sets each instruction's opcode before its first fetch beat and holds it for the whole instruction. Two unsupported opcodes are included. A reset is also applied in the middle of an instruction, with no comparisons expected while reset is held.

// File: rtl/mcsq_pkg.sv
package mcsq_pkg;
  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_MEM_ADDR, ST_MEM_LOAD, ST_LOAD_WB, ST_MEM_STORE,
    ST_R_EXEC, ST_R_WB, ST_BRANCH, ST_JUMP, ST_I_EXEC, ST_I_WB
  } state_e;

  localparam logic [5:0] OP_RTYPE = 6'b000000;
  localparam logic [5:0] OP_ADDI  = 6'b001000;
  localparam logic [5:0] OP_LB    = 6'b100000;
  localparam logic [5:0] OP_SB    = 6'b101000;
  localparam logic [5:0] OP_BEQ   = 6'b000100;
  localparam logic [5:0] OP_J     = 6'b000010;

  localparam logic [1:0] ALU_ADD   = 2'd0;
  localparam logic [1:0] ALU_SUB   = 2'd1;
  localparam logic [1:0] ALU_FUNCT = 2'd2;

  localparam logic [1:0] BSEL_REG  = 2'd0;
  localparam logic [1:0] BSEL_ONE  = 2'd1;
  localparam logic [1:0] BSEL_IMM  = 2'd2;
  localparam logic [1:0] BSEL_OFFS = 2'd3;

  localparam logic [1:0] PCSEL_ALU  = 2'd0;
  localparam logic [1:0] PCSEL_OUT  = 2'd1;
  localparam logic [1:0] PCSEL_JUMP = 2'd2;

  typedef struct packed {
    logic       pc_we;
    logic       pc_we_cond;
    logic [1:0] pc_sel;
    logic       addr_sel;
    logic       mem_rd;
    logic       mem_wr;
    logic       alu_a_sel;
    logic [1:0] alu_b_sel;
    logic [1:0] alu_op;
    logic       reg_dst;
    logic       wb_sel;
    logic       reg_we;
  } ctrl_t;

  function automatic state_e dispatch(input logic [5:0] op);
    case (op)
      OP_RTYPE: return ST_R_EXEC;
      OP_ADDI:  return ST_I_EXEC;
      OP_LB,
      OP_SB:    return ST_MEM_ADDR;
      OP_BEQ:   return ST_BRANCH;
      OP_J:     return ST_JUMP;
      default:  return ST_FETCH;
    endcase
  endfunction
endpackage

// File: rtl/mcsq_next.sv
module mcsq_next
  import mcsq_pkg::*;
#(
  parameter int FETCH_BEATS = 4,
  localparam int BW = (FETCH_BEATS > 1) ? $clog2(FETCH_BEATS) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [5:0]    opcode_i,
  output state_e        state_o,
  output logic [BW-1:0] beat_o
);
  localparam logic [BW-1:0] LAST_BEAT = BW'(FETCH_BEATS - 1);

  state_e        state_q, state_d;
  logic [BW-1:0] beat_q, beat_d;

  always_comb begin
    state_d = state_q;
    beat_d  = beat_q;
    unique case (state_q)
      ST_FETCH: begin
        if (beat_q == LAST_BEAT) begin
          state_d = ST_DECODE;
          beat_d  = '0;
        end else begin
          beat_d = beat_q + 1'b1;
        end
      end
      ST_DECODE:   state_d = dispatch(opcode_i);
      ST_MEM_ADDR: state_d = (opcode_i == OP_SB) ? ST_MEM_STORE : ST_MEM_LOAD;
      ST_MEM_LOAD: state_d = ST_LOAD_WB;
      ST_R_EXEC:   state_d = ST_R_WB;
      ST_I_EXEC:   state_d = ST_I_WB;
      default:     state_d = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_FETCH;
      beat_q  <= '0;
    end else begin
      state_q <= state_d;
      beat_q  <= beat_d;
    end
  end

  assign state_o = state_q;
  assign beat_o  = beat_q;
endmodule

// File: rtl/mcsq_decode.sv
module mcsq_decode
  import mcsq_pkg::*;
#(
  parameter int FETCH_BEATS = 4,
  localparam int BW = (FETCH_BEATS > 1) ? $clog2(FETCH_BEATS) : 1
) (
  input  state_e                 state_i,
  input  logic [BW-1:0]          beat_i,
  output ctrl_t                  ctrl_o,
  output logic [FETCH_BEATS-1:0] ir_we_o
);
  for (genvar i = 0; i < FETCH_BEATS; i++) begin : g_lane
    localparam logic [BW-1:0] IDX = BW'(i);
    assign ir_we_o[i] = (state_i == ST_FETCH) && (beat_i == IDX);
  end

  always_comb begin
    ctrl_o = '0;
    unique case (state_i)
      ST_FETCH: begin
        ctrl_o.mem_rd    = 1'b1;
        ctrl_o.alu_b_sel = BSEL_ONE;
        ctrl_o.alu_op    = ALU_ADD;
        ctrl_o.pc_we     = 1'b1;
        ctrl_o.pc_sel    = PCSEL_ALU;
      end
      ST_DECODE: ctrl_o.alu_b_sel = BSEL_OFFS;
      ST_MEM_ADDR, ST_I_EXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_b_sel = BSEL_IMM;
      end
      ST_MEM_LOAD: begin
        ctrl_o.mem_rd   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      ST_LOAD_WB: begin
        ctrl_o.reg_we = 1'b1;
        ctrl_o.wb_sel = 1'b1;
      end
      ST_MEM_STORE: begin
        ctrl_o.mem_wr   = 1'b1;
        ctrl_o.addr_sel = 1'b1;
      end
      ST_R_EXEC: begin
        ctrl_o.alu_a_sel = 1'b1;
        ctrl_o.alu_op    = ALU_FUNCT;
      end
      ST_R_WB: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.reg_dst = 1'b1;
      end
      ST_I_WB: ctrl_o.reg_we = 1'b1;
      ST_BRANCH: begin
        ctrl_o.alu_a_sel  = 1'b1;
        ctrl_o.alu_op     = ALU_SUB;
        ctrl_o.pc_we_cond = 1'b1;
        ctrl_o.pc_sel     = PCSEL_OUT;
      end
      ST_JUMP: begin
        ctrl_o.pc_we  = 1'b1;
        ctrl_o.pc_sel = PCSEL_JUMP;
      end
      default: ctrl_o = '0;
    endcase
  end
endmodule

// File: rtl/mcsq_ctrl.sv
module mcsq_ctrl
  import mcsq_pkg::*;
#(
  parameter int FETCH_BEATS = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [5:0]             opcode_i,
  output logic                   pc_we_o,
  output logic                   pc_we_cond_o,
  output logic [1:0]             pc_sel_o,
  output logic                   addr_sel_o,
  output logic                   mem_rd_o,
  output logic                   mem_wr_o,
  output logic [FETCH_BEATS-1:0] ir_we_o,
  output logic                   alu_a_sel_o,
  output logic [1:0]             alu_b_sel_o,
  output logic [1:0]             alu_op_o,
  output logic                   reg_dst_o,
  output logic                   wb_sel_o,
  output logic                   reg_we_o
);
  localparam int BW = (FETCH_BEATS > 1) ? $clog2(FETCH_BEATS) : 1;

  state_e        state;
  logic [BW-1:0] beat;
  ctrl_t         ctrl;

  mcsq_next #(.FETCH_BEATS(FETCH_BEATS)) u_next (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .opcode_i (opcode_i),
    .state_o  (state),
    .beat_o   (beat)
  );

  mcsq_decode #(.FETCH_BEATS(FETCH_BEATS)) u_decode (
    .state_i (state),
    .beat_i  (beat),
    .ctrl_o  (ctrl),
    .ir_we_o (ir_we_o)
  );

  assign pc_we_o      = ctrl.pc_we;
  assign pc_we_cond_o = ctrl.pc_we_cond;
  assign pc_sel_o     = ctrl.pc_sel;
  assign addr_sel_o   = ctrl.addr_sel;
  assign mem_rd_o     = ctrl.mem_rd;
  assign mem_wr_o     = ctrl.mem_wr;
  assign alu_a_sel_o  = ctrl.alu_a_sel;
  assign alu_b_sel_o  = ctrl.alu_b_sel;
  assign alu_op_o     = ctrl.alu_op;
  assign reg_dst_o    = ctrl.reg_dst;
  assign wb_sel_o     = ctrl.wb_sel;
  assign reg_we_o     = ctrl.reg_we;
endmodule

// File: rtl/mcsq_ctrl_chk.sv
module mcsq_ctrl_chk #(
  parameter int FETCH_BEATS = 4
) (
  input logic                   clk_i,
  input logic                   rst_ni,
  input logic [5:0]             opcode_i,
  input logic                   pc_we_o,
  input logic                   pc_we_cond_o,
  input logic [1:0]             pc_sel_o,
  input logic                   addr_sel_o,
  input logic                   mem_rd_o,
  input logic                   mem_wr_o,
  input logic [FETCH_BEATS-1:0] ir_we_o,
  input logic                   alu_a_sel_o,
  input logic [1:0]             alu_b_sel_o,
  input logic [1:0]             alu_op_o,
  input logic                   reg_dst_o,
  input logic                   wb_sel_o,
  input logic                   reg_we_o
);
  AST_IR_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ir_we_o)); // R12
  AST_MEM_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_rd_o && mem_wr_o)); // R12
  AST_PC_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pc_we_o && pc_we_cond_o)); // R12
  AST_FETCH_CTRL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|ir_we_o) |-> (mem_rd_o && pc_we_o && !addr_sel_o && alu_b_sel_o == 2'd1 && pc_sel_o == 2'd0)); // R2

  for (genvar i = 0; i < FETCH_BEATS - 1; i++) begin : g_order
    AST_FETCH_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ir_we_o[i] |=> ir_we_o[i+1]); // R2
  end

  AST_DECODE_AFTER_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ir_we_o[FETCH_BEATS-1] |=> (alu_b_sel_o == 2'd3 && !pc_we_o && !reg_we_o && !mem_rd_o && !mem_wr_o)); // R3
  AST_JUMP_DISPATCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_b_sel_o == 2'd3 && opcode_i == 6'b000010) |=> (pc_we_o && pc_sel_o == 2'd2)); // R10
  AST_WB_TO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> ir_we_o[0]); // R5
  AST_STORE_TO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_o |=> ir_we_o[0]); // R8
  AST_BRANCH_TO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_cond_o |=> ir_we_o[0]); // R9
  AST_LOAD_DEST_RT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_we_o && wb_sel_o) |-> !reg_dst_o); // R7
  AST_FUNCT_USES_REGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alu_op_o == 2'd2) |-> (alu_a_sel_o && alu_b_sel_o == 2'd0)); // R5
endmodule

bind mcsq_ctrl mcsq_ctrl_chk #(.FETCH_BEATS(FETCH_BEATS)) u_chk (.*);

// File: tb/mcsq_ctrl_bench.sv
module mcsq_ctrl_bench;
  localparam int NB = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [5:0]    opcode = 6'd0;
  logic          pc_we, pc_we_cond, addr_sel, mem_rd, mem_wr, alu_a_sel;
  logic          reg_dst, wb_sel, reg_we;
  logic [1:0]    pc_sel, alu_b_sel, alu_op;
  logic [NB-1:0] ir_we;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic [18:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  mcsq_ctrl #(.FETCH_BEATS(NB)) u_mcsq_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .opcode_i(opcode),
    .pc_we_o(pc_we), .pc_we_cond_o(pc_we_cond), .pc_sel_o(pc_sel),
    .addr_sel_o(addr_sel), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .ir_we_o(ir_we), .alu_a_sel_o(alu_a_sel), .alu_b_sel_o(alu_b_sel),
    .alu_op_o(alu_op), .reg_dst_o(reg_dst), .wb_sel_o(wb_sel), .reg_we_o(reg_we)
  );

  function automatic logic [18:0] cv(logic pw, logic pwc, logic [1:0] ps, logic as,
      logic mr, logic mw, logic [3:0] ir, logic a, logic [1:0] b, logic [1:0] op,
      logic rd, logic wb, logic rw);
    return {pw, pwc, ps, as, mr, mw, ir, a, b, op, rd, wb, rw};
  endfunction

  function automatic logic [18:0] actual();
    return {pc_we, pc_we_cond, pc_sel, addr_sel, mem_rd, mem_wr, ir_we,
            alu_a_sel, alu_b_sel, alu_op, reg_dst, wb_sel, reg_we};
  endfunction

  function automatic logic [18:0] v_fetch(int k);
    return cv(1, 0, 0, 0, 1, 0, 4'(1 << k), 0, 1, 0, 0, 0, 0);
  endfunction

  task automatic check(string tag, logic [18:0] act, logic [18:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic push(logic [18:0] v, string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
  endtask

  // driver: queue one instruction's expected cycles, hold its opcode for their duration
  task automatic run_instr(logic [5:0] op);
    int n = 0;
    for (int k = 0; k < NB; k++) begin push(v_fetch(k), "R2"); n++; end
    push(cv(0, 0, 0, 0, 0, 0, 0, 0, 3, 0, 0, 0, 0), "R3"); n++;
    case (op)
      6'b000000: begin
        push(cv(0, 0, 0, 0, 0, 0, 0, 1, 0, 2, 0, 0, 0), "R4,R5 exec");
        push(cv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 1), "R5 wb"); n += 2;
      end
      6'b001000: begin
        push(cv(0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 0, 0), "R4,R6 exec");
        push(cv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1), "R6 wb"); n += 2;
      end
      6'b100000: begin
        push(cv(0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 0, 0), "R4,R7 addr");
        push(cv(0, 0, 0, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0), "R7 read");
        push(cv(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, 1), "R7 wb"); n += 3;
      end
      6'b101000: begin
        push(cv(0, 0, 0, 0, 0, 0, 0, 1, 2, 0, 0, 0, 0), "R4,R8 addr");
        push(cv(0, 0, 0, 1, 0, 1, 0, 0, 0, 0, 0, 0, 0), "R8 write"); n += 2;
      end
      6'b000100: begin
        push(cv(0, 1, 1, 0, 0, 0, 0, 1, 0, 1, 0, 0, 0), "R4,R9 branch"); n++;
      end
      6'b000010: begin
        push(cv(1, 0, 2, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0), "R4,R10 jump"); n++;
      end
      default: ; // R11: next instruction's fetch beat 0 confirms the return
    endcase
    opcode = op;
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor: compare mid-cycle against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && exp_q.size() > 0) begin
      logic [18:0] e;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      check(t, actual(), e);
      checks++;
      if (mem_rd && mem_wr) begin
        errors++;
        $display("FAIL R12: mem_rd=%b mem_wr=%b expected not both", mem_rd, mem_wr);
      end
    end
  end

  initial begin
    #1;
    check("R1 in reset", actual(), v_fetch(0));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    run_instr(6'b000000);
    run_instr(6'b001000);
    run_instr(6'b100000);
    run_instr(6'b101000);
    run_instr(6'b000100);
    run_instr(6'b000010);
    run_instr(6'b111111);            // R11
    run_instr(6'b000000);
    run_instr(6'b001101);            // R11
    run_instr(6'b100000);
    // mid-instruction reset: R1
    opcode = 6'b000010;
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b0;
    #2 check("R1 async reset", actual(), v_fetch(0));
    @(posedge clk);
    #1 rst_n = 1'b1;
    #2 check("R1 after release", actual(), v_fetch(0));
    #1;
    run_instr(6'b101000);
    run_instr(6'b000100);
    @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule